// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Bank

This block is a slave on a two-wire serial bus (I2C) that holds eight byte-wide configuration registers and presents them together as one 64-bit vector to a clock-synthesis datapath. The bus master writes a register pointer, then streams data bytes into consecutive registers. It can also issue a repeated START with the read bit and stream register contents back out. Both bus lines are oversampled by the system clock. The block only ever pulls the data line low or lets it go, as an open-drain driver would.

A register changes on the SCL falling edge that starts its acknowledge slot, not at STOP, and a one-cycle commit strobe marks each update. The pointer wraps after the last register, in both directions of transfer. Bits of an unfinished byte are thrown away when a STOP or a repeated START cuts the byte short. The device address is a fixed five-bit prefix followed by two strap inputs.

Protocol states: `ST_IDLE` (not addressed), `ST_DEVADDR` (shifting in the address byte), `ST_DEVACK` (acknowledging the address), `ST_PTR` / `ST_PTRACK` (pointer byte and its acknowledge), `ST_WBYTE` / `ST_WACK` (data byte and its acknowledge), `ST_RBYTE` (shifting a byte out), `ST_RACK` (sampling the master's acknowledge). Transitions are as follows:
- Any state goes to `ST_DEVADDR` on START and to `ST_IDLE` on STOP.
- `ST_DEVADDR` goes to `ST_DEVACK` on an address match after eight bits, or to `ST_IDLE` on a mismatch.
- `ST_DEVACK` goes to `ST_PTR` for a write or to `ST_RBYTE` for a read.
- `ST_PTR` goes to `ST_PTRACK`, then to `ST_WBYTE`.
- `ST_WBYTE` and `ST_WACK` alternate.
- `ST_RBYTE` goes to `ST_RACK`. From there the block returns to `ST_RBYTE` on an acknowledge, or to `ST_IDLE` on a not-acknowledge.

Top module: `cfg_i2c_bank`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 10110 followed by `addr_sel[1:0]`. Any other address, including the all-zero general call, gets no acknowledge, and later bytes until the next START have no effect.
- R2: The first byte after an acknowledged write address loads the register pointer from its low three bits; bits 7:3 of that byte are ignored.
- R3: Each later write byte, received MSB first, is stored in the register at the pointer, and the pointer then increments. The store happens when the acknowledge for that byte begins, and `commit_stb` pulses for exactly one cycle per stored byte.
- R4: After register 7 the pointer wraps to register 0, so a ninth consecutive byte overwrites the first register written.
- R5: A STOP or repeated START that arrives before the eighth bit of a data byte discards that byte: no register changes, no strobe fires, and the pointer keeps its value.
- R6: After a repeated START with the read bit, the block sends the register at the pointer MSB first, increments the pointer with wrap after each byte, and continues while the master acknowledges.
- R7: When the master does not acknowledge a read byte, the block releases SDA and stops transmitting until the next START.
- R8: After reset every register is zero. `cfg_vec[8*i+7:8*i]` always equals register i, and the value of every written bit is preserved exactly.
- R9: `sda_oe` changes only while SCL is low. During each acknowledge slot the block issues, it holds SDA low for the whole ninth clock pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| addr_sel | input | 2 | Strap bits forming the low two bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_vec | output | 64 | All eight registers, register i at bits 8*i+7:8*i |
| commit_stb | output | 1 | One-cycle pulse when a register byte is stored |

## Verification
The bench keeps a behavioural register image and pointer, updates them once per completed data byte, and compares them against `cfg_vec` on every clock. A design that committed at STOP instead of at each acknowledge, or that stored a half-received byte, would diverge in that window. Pointer bytes with high bits set and nine-byte bursts are aimed at designs that use the full pointer byte or fail to wrap, which would write the wrong register or lose the ninth byte. Reads that cross the wrap and end with a not-acknowledge catch a slave that keeps driving SDA afterwards. Wrong-address and general-call traffic catches a slave that answers when it should stay silent.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_PTR,
        ST_PTRACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK
    } bus_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // The bus idles high, so the synchronizer chains reset to one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_pin};
            sda_chain <= {sda_chain[STAGES-2:0], sda_pin};
            scl_prev  <= scl_chain[STAGES-1];
            sda_prev  <= sda_chain[STAGES-1];
        end
    end

    assign scl_lvl   = scl_chain[STAGES-1];
    assign sda_lvl   = sda_chain[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int VEC_W   = NUM_REGS * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_data,
    output logic [VEC_W-1:0] cfg_vec
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                q <= wr_data;
        end
        assign cfg_vec[g*REG_W +: REG_W] = q;
    end

    assign rd_data = cfg_vec[rd_idx*REG_W +: REG_W];

    // R3 / R8: a write lands in exactly the addressed slice.
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_vec[$past(wr_idx)*REG_W +: REG_W] == $past(wr_data));

    // R5 / R8: without a write, the register image holds.
    assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_vec));

endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
    import cfgbank_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter int         SEL_W    = 2,
    parameter logic [6:0] DEV_BASE = 7'b1011000,
    localparam int        IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              sda_oe
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    bus_state_t        state, state_n;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [IDX_W-1:0]  ptr;
    logic              nack_q;
    logic [6:0]        dev_addr;
    logic              byte_done;
    logic              rx_state;

    assign dev_addr  = {DEV_BASE[6:SEL_W], addr_sel};
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign rx_state  = (state == ST_DEVADDR) || (state == ST_PTR) ||
                       (state == ST_WBYTE)   || (state == ST_RBYTE);

    function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Next-state decode
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_DEVADDR;
        end else begin
            unique case (state)
                ST_IDLE:    state_n = ST_IDLE;
                ST_DEVADDR: if (byte_done)
                                state_n = (shreg[7:1] == dev_addr) ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:  if (scl_fall) state_n = shreg[0] ? ST_RBYTE : ST_PTR;
                ST_PTR:     if (byte_done) state_n = ST_PTRACK;
                ST_PTRACK:  if (scl_fall) state_n = ST_WBYTE;
                ST_WBYTE:   if (byte_done) state_n = ST_WACK;
                ST_WACK:    if (scl_fall) state_n = ST_WBYTE;
                ST_RBYTE:   if (byte_done) state_n = ST_RACK;
                ST_RACK:    if (scl_fall) state_n = nack_q ? ST_IDLE : ST_RBYTE;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            nack_q  <= 1'b1;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            if (scl_rise && rx_state) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_rise && state == ST_RACK)
                nack_q <= sda_lvl;
            if (scl_fall) begin
                unique case (state)
                    ST_DEVADDR: if (byte_done) bit_cnt <= '0;
                    ST_DEVACK:  if (shreg[0]) txreg <= rd_data;
                    ST_PTR:     if (byte_done) begin
                                    ptr     <= shreg[IDX_W-1:0];
                                    bit_cnt <= '0;
                                end
                    ST_WBYTE:   if (byte_done) begin
                                    ptr     <= ptr_next(ptr);
                                    bit_cnt <= '0;
                                end
                    ST_RBYTE:   if (byte_done) begin
                                    ptr     <= ptr_next(ptr);
                                    bit_cnt <= '0;
                                end else begin
                                    txreg <= {txreg[BYTE_W-2:0], 1'b0};
                                end
                    ST_RACK:    if (!nack_q) txreg <= rd_data;
                    default:    ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_DEVACK, ST_PTRACK, ST_WACK: sda_oe = 1'b1;
            ST_RBYTE:                      sda_oe = ~txreg[BYTE_W-1];
            default:                       sda_oe = 1'b0;
        endcase
        wr_en   = (state == ST_WBYTE) && byte_done && !start_det && !stop_det;
        wr_idx  = ptr;
        wr_data = shreg;
        rd_idx  = ptr;
    end

    // R9: the data line driver moves only while the clock line is low.
    assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R4: the pointer wraps to zero after the last register.
    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == LAST_IDX) |=> ptr == '0);

    // R7: a not-acknowledge ends the read and releases the line.
    assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && nack_q && !start_det && !stop_det)
            |=> (state == ST_IDLE && !sda_oe));

    // R5: START or STOP clears the bit count.
    assert_partial_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> bit_cnt == '0);

    // R1: the address acknowledge only follows a matching address.
    assert_addr_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DEVACK) |-> $past(shreg[7:1]) == dev_addr);

    // R3: a commit happens only while the clock line is low.
    assert_commit_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_lvl);

endmodule

// File: rtl/cfg_i2c_bank.sv
module cfg_i2c_bank #(
    parameter int NUM_REGS = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W = NUM_REGS * cfgbank_pkg::BYTE_W,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       addr_sel,
    output logic             sda_oe,
    output logic [CFG_W-1:0] cfg_vec,
    output logic             commit_stb
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic                            wr_en;
    logic [IDX_W-1:0]                wr_idx, rd_idx;
    logic [cfgbank_pkg::BYTE_W-1:0]  wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_pin   (scl_i),
        .sda_pin   (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_cfg_fsm #(.NUM_REGS(NUM_REGS), .SEL_W(2)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe)
    );

    cfg_regfile #(.NUM_REGS(NUM_REGS), .REG_W(cfgbank_pkg::BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cfg_vec (cfg_vec)
    );

    assign commit_stb = wr_en;

endmodule

// File: tb/test_cfg_i2c_bank.sv
module test_cfg_i2c_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b01;
    logic        sda_oe;
    logic [63:0] cfg_vec;
    logic        commit_stb;
    logic        sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    cfg_i2c_bank i_cfg_i2c_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_sel   (addr_sel),
        .sda_oe     (sda_oe),
        .cfg_vec    (cfg_vec),
        .commit_stb (commit_stb)
    );

    always #5 clk = ~clk;

    int   n_chk = 0;
    int   n_bad = 0;
    int   stb_cnt = 0;
    int   exp_stb = 0;
    logic [7:0] mem [8];
    int   mptr = 0;
    bit   cmp_on = 1'b0;
    logic prev_oe = 1'b0;

    function automatic logic [63:0] model_vec();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = mem[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Reference image compared on every clock (R8, R3, R5)
    always @(negedge clk) begin
        if (rst_n && cmp_on)
            chk(cfg_vec === model_vec(), "R8", "register image", cfg_vec, model_vec());
    end

    // R9: driver changes only while the clock line is low
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe)
            chk(!scl_m, "R9", "sda_oe moved with SCL high", {63'd0, scl_m}, 64'd0);
        prev_oe = sda_oe;
    end

    always @(posedge clk) if (rst_n && commit_stb) stb_cnt++;

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(5);
        scl_m = 1'b1; tick(5);
        sda_m = 1'b0; tick(5);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(5);
        scl_m = 1'b1; tick(5);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(4);
            scl_m = 1'b1; tick(8);
            scl_m = 1'b0; tick(4);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit commit, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(4);
            scl_m = 1'b1; tick(8);
            if (i == 0 && commit) cmp_on = 1'b0;
            scl_m = 1'b0;
            if (i == 0 && commit) begin
                tick(8);
                mem[mptr] = b;
                mptr = (mptr + 1) % 8;
                exp_stb++;
                cmp_on = 1'b1;
            end else begin
                tick(4);
            end
        end
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(4);
        acked = (sda_bus == 1'b0);
        tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit master_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(4);
            scl_m = 1'b1; tick(4);
            b[i] = sda_bus;
            tick(4);
            scl_m = 1'b0;
        end
        tick(4);
        sda_m = master_ack ? 1'b0 : 1'b1; tick(4);
        scl_m = 1'b1; tick(8);
        scl_m = 1'b0; tick(4);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic [1:0] sel, input bit rd);
        return {5'b10110, sel, rd};
    endfunction

    // Write: address, pointer byte, then data bytes (R1, R2, R3, R4)
    task automatic wr_txn(input logic [1:0] sel, input logic [7:0] ptrb,
                          input logic [7:0] data [$]);
        bit ack;
        bus_start();
        send_byte(dev_byte(sel, 1'b0), 1'b0, ack);
        chk(ack, "R1", "address acknowledge", {63'd0, ack}, 64'd1);
        send_byte(ptrb, 1'b0, ack);
        mptr = ptrb & 8'h07;
        chk(ack, "R2", "pointer acknowledge", {63'd0, ack}, 64'd1);
        foreach (data[k]) begin
            send_byte(data[k], 1'b1, ack);
            chk(ack, "R3", "data acknowledge", {63'd0, ack}, 64'd1);
        end
        bus_stop();
        chk(stb_cnt == exp_stb, "R3", "commit strobe count", 64'(stb_cnt), 64'(exp_stb));
    endtask

    // Random/sequential read across the wrap, ended by a not-acknowledge (R6, R7)
    task automatic rd_txn(input logic [7:0] ptrb, input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b0), 1'b0, ack);
        send_byte(ptrb, 1'b0, ack);
        mptr = ptrb & 8'h07;
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b1), 1'b0, ack);
        chk(ack, "R6", "read address acknowledge", {63'd0, ack}, 64'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            chk(b === mem[mptr], "R6", "read byte", 64'(b), 64'(mem[mptr]));
            mptr = (mptr + 1) % 8;
        end
        tick(4);
        chk(sda_oe === 1'b0, "R7", "SDA released after NACK", {63'd0, sda_oe}, 64'd0);
        send_bits(8'h00, 2);
        chk(sda_oe === 1'b0, "R7", "no transmit after NACK", {63'd0, sda_oe}, 64'd0);
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        logic [7:0] q [$];
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R8: reset state
        chk(cfg_vec === 64'd0, "R8", "reset image", cfg_vec, 64'd0);
        chk(sda_oe === 1'b0, "R8", "reset driver", {63'd0, sda_oe}, 64'd0);
        cmp_on = 1'b1;

        // R3: fill all eight registers from pointer 0
        q = '{8'h11, 8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h80, 8'h01, 8'h3C};
        wr_txn(addr_sel, 8'h00, q);

        // R2 + R4: pointer byte with high bits set, burst crosses the wrap
        q = '{8'hC3, 8'h7E, 8'h96, 8'h69};
        wr_txn(addr_sel, 8'hFE, q);

        // R4: nine bytes from pointer 0, the ninth overwrites register 0
        q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'hE9};
        wr_txn(addr_sel, 8'h00, q);

        // R1: other strap value is ignored, bytes after it have no effect
        bus_start();
        send_byte(dev_byte(2'b10, 1'b0), 1'b0, ack);
        chk(!ack, "R1", "foreign address not acknowledged", {63'd0, ack}, 64'd0);
        send_byte(8'h02, 1'b0, ack);
        send_byte(8'hDE, 1'b0, ack);
        bus_stop();
        // R1: general call ignored
        bus_start();
        send_byte(8'h00, 1'b0, ack);
        chk(!ack, "R1", "general call not acknowledged", {63'd0, ack}, 64'd0);
        send_byte(8'h03, 1'b0, ack);
        send_byte(8'hAD, 1'b0, ack);
        bus_stop();
        chk(stb_cnt == exp_stb, "R1", "no strobe for foreign traffic", 64'(stb_cnt), 64'(exp_stb));

        // R5: partial byte then STOP
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b0), 1'b0, ack);
        send_byte(8'h03, 1'b0, ack);
        mptr = 3;
        send_bits(8'hF0, 4);
        bus_stop();
        chk(stb_cnt == exp_stb, "R5", "no strobe on STOP mid-byte", 64'(stb_cnt), 64'(exp_stb));

        // R5: partial byte then repeated START into a read; pointer unchanged
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b0), 1'b0, ack);
        send_byte(8'h02, 1'b0, ack);
        mptr = 2;
        send_bits(8'h0F, 5);
        bus_start();
        send_byte(dev_byte(addr_sel, 1'b1), 1'b0, ack);
        recv_byte(b, 1'b0);
        chk(b === mem[2], "R5", "pointer kept after cut byte", 64'(b), 64'(mem[2]));
        bus_stop();
        chk(stb_cnt == exp_stb, "R5", "no strobe on repeated START mid-byte", 64'(stb_cnt), 64'(exp_stb));

        // R6 + R7: read four bytes across the wrap
        rd_txn(8'h05, 4);
        // R6: full eight-byte read from register 3
        rd_txn(8'h03, 8);

        // R1: new strap value takes effect
        addr_sel = 2'b10;
        tick(4);
        q = '{8'hB7};
        wr_txn(addr_sel, 8'h04, q);
        rd_txn(8'h04, 1);

        tick(20);
        summary();
        $finish;
    end

endmodule